// File: doc/BRIEF.md
# Snoop-Side Invalidate Queue with Load Barrier

This block sits between the snooping bus interface and the tag array of a cache that keeps lines in the Modified, Exclusive, Shared and Invalid states. Every invalidate snooped from the bus is taken into a small first-in first-out queue and acknowledged in the same cycle. The acknowledge does not wait for the cache. Queued entries are replayed onto the tag port in the background, one per cycle, whenever the core is not using that port. The cache array turns a line Invalid when the address of a replayed command matches a valid line. A command that matches no valid line changes nothing.

The ack is decoupled from the tag update, so a core load can still hit a line marked Shared while an invalidate for that line waits in the queue. Such a load returns the old value. Software that needs the new value raises the load-barrier request. The block then holds the load-stall output high until the queue is empty. While loads are stalled the tag port is free, so the queue drains at one entry per cycle.

The snoop input is a valid/ready stream. The address is transferred, and acknowledged, in a cycle where `snp_valid` and `snp_ready` are both high. `snp_ready` is low only while the queue is full. The snooper must then hold `snp_valid` and `snp_addr` steady until `snp_ready` returns.

Top module: `inval_queue`

## Requirements
- R1: After reset the queue is empty: `snp_ready` is 1, `tag_inv_valid` is 0 and `ld_stall` is 0.
- R2: With fewer than DEPTH entries held, `snp_ready` is 1, so a snooped invalidate is accepted and acknowledged in the cycle it is presented, even while a core load holds the tag port.
- R3: An accepted address first appears on `tag_inv_addr` (with `tag_inv_valid` = 1) no earlier than the cycle after acceptance. It appears unchanged. In the bench cache model it then turns only the line holding that exact address Invalid.
- R4: Tag commands leave in arrival order, at most one per cycle, and back-to-back when the tag port is free.
- R5: In a cycle where `ld_req` = 1 and `ld_stall` = 0, the core owns the tag port and `tag_inv_valid` is 0.
- R6: With DEPTH entries held, `snp_ready` is 0 and the held invalidate is not taken. It is accepted in the first cycle after an entry has been applied.
- R7: A `fence_req` pulse with a non-empty queue raises `ld_stall` in the same cycle. `ld_stall` stays 1 until the entry count reaches zero and drops in the cycle the queue is empty.
- R8: A `fence_req` with an empty queue leaves `ld_stall` at 0.
- R9: Without a barrier, `ld_stall` stays 0 while entries are pending, so a load may read a still-Shared line and obtain its old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped invalidate present |
| snp_ready | output | 1 | Queue can take it; handshake is the acknowledge |
| snp_addr | input | AW | Line address of the snooped invalidate |
| ld_req | input | 1 | Core load wants the tag port this cycle |
| fence_req | input | 1 | Load-barrier request, one-cycle pulse |
| ld_stall | output | 1 | Core load must wait; queue still draining under a barrier |
| tag_inv_valid | output | 1 | Invalidate command to the tag array this cycle |
| tag_inv_addr | output | AW | Address of that command, oldest queued entry |

## Verification
`snp_ready` and `ld_stall` are combinational from the current count and requests. The bench checks them one nanosecond after it drives the inputs on the falling edge, within the same cycle. The earliest a tag command can follow an accepted snoop is one clock edge, the queue write. The bench records every command at the rising edge into a log and compares the logged order against the pushed order. It reads the cache model only after the edge on which a command is applied. The barrier test counts the stalled cycles: with N entries queued and the core parked on the stall, the stall lasts exactly N cycles.

// File: rtl/ivq_pkg.sv
package ivq_pkg;

  localparam int IVQ_DEF_DEPTH = 4;
  localparam int IVQ_DEF_AW    = 16;

  // owner of the tag port in a given cycle
  typedef enum logic [1:0] {
    TP_IDLE  = 2'd0,
    TP_CORE  = 2'd1,
    TP_INVAL = 2'd2
  } tag_owner_e;

endpackage

// File: rtl/ivq_fifo.sv
module ivq_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic                         pop,
  output logic [AW-1:0]                head_addr,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_next,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign cnt   = cnt_q;
  assign head_addr = slot_q[rd_q];

  always_comb begin
    cnt_next = cnt_q;
    if (push && !pop) cnt_next = cnt_q + 1'b1;
    else if (pop && !push) cnt_next = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_q == PW'(i)) slot_q[i] <= push_addr;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH))); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> ((cnt_q >= $past(cnt_q) - 1'b1) && (cnt_q <= $past(cnt_q) + 1'b1))); // R4
endmodule

// File: rtl/ivq_port_arb.sv
module ivq_port_arb
  import ivq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_req,
  input  logic ld_stall,
  input  logic have_entry,
  output logic apply,
  output tag_owner_e owner
);
  logic core_go;
  assign core_go = ld_req && !ld_stall;

  always_comb begin
    if (core_go)         owner = TP_CORE;
    else if (have_entry) owner = TP_INVAL;
    else                 owner = TP_IDLE;
  end

  assign apply = (owner == TP_INVAL);

  AST_TAG_FREE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stall && have_entry) |-> apply); // R7
endmodule

// File: rtl/ivq_fence.sv
module ivq_fence #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fence_req,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_next,
  output logic          ld_stall
);
  logic pend_q;
  logic armed;

  assign armed    = fence_req || pend_q;
  assign ld_stall = armed && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= armed && (cnt_next != '0);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |=> (ld_stall || (cnt == '0))); // R7
endmodule

// File: rtl/inval_queue.sv
module inval_queue
  import ivq_pkg::*;
#(
  parameter int DEPTH = IVQ_DEF_DEPTH,
  parameter int AW    = IVQ_DEF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  output logic          snp_ready,
  input  logic [AW-1:0] snp_addr,
  input  logic          ld_req,
  input  logic          fence_req,
  output logic          ld_stall,
  output logic          tag_inv_valid,
  output logic [AW-1:0] tag_inv_addr
);
  localparam int CW = $clog2(DEPTH+1);

  logic          push, pop, full, empty;
  logic [CW-1:0] cnt, cnt_next;
  logic [AW-1:0] head_addr;
  tag_owner_e    owner;

  assign snp_ready = !full;
  assign push      = snp_valid && snp_ready;

  ivq_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(snp_addr),
    .pop(pop), .head_addr(head_addr),
    .cnt(cnt), .cnt_next(cnt_next),
    .full(full), .empty(empty)
  );

  ivq_fence #(.CW(CW)) u_fence (
    .clk(clk), .rst_n(rst_n),
    .fence_req(fence_req), .cnt(cnt), .cnt_next(cnt_next),
    .ld_stall(ld_stall)
  );

  ivq_port_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_req), .ld_stall(ld_stall),
    .have_entry(!empty),
    .apply(pop), .owner(owner)
  );

  assign tag_inv_valid = pop;
  assign tag_inv_addr  = head_addr;

  AST_ACK_BEFORE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (push && empty) |-> !tag_inv_valid); // R3
  AST_CORE_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_stall) |-> !tag_inv_valid); // R5
  AST_READY_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!full) |-> snp_ready); // R2
  AST_NO_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !ld_stall); // R8
endmodule

// File: tb/inval_queue_tb.sv
module inval_queue_tb;
  localparam int DEPTH = 4;
  localparam int AW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snp_valid = 1'b0, ld_req = 1'b0, fence_req = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_ready, ld_stall, tag_inv_valid;
  logic [AW-1:0] tag_inv_addr;

  always #2.5 clk = ~clk;

  inval_queue #(.DEPTH(DEPTH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr),
    .ld_req(ld_req), .fence_req(fence_req), .ld_stall(ld_stall),
    .tag_inv_valid(tag_inv_valid), .tag_inv_addr(tag_inv_addr)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // cache model: 8 lines indexed by addr[2:0], state 1 = Shared, 0 = Invalid
  logic [AW-1:0] c_tag [8];
  logic          c_sh  [8];
  logic [7:0]    c_dat [8];
  logic          pl_en = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0]    pl_dat = '0;

  // log of applied tag commands
  logic [AW-1:0] lg [64];
  int lg_n = 0;

  always @(posedge clk) begin
    if (pl_en) begin
      c_tag[pl_addr[2:0]] <= pl_addr;
      c_sh[pl_addr[2:0]]  <= 1'b1;
      c_dat[pl_addr[2:0]] <= pl_dat;
    end else if (tag_inv_valid && c_sh[tag_inv_addr[2:0]] &&
                 c_tag[tag_inv_addr[2:0]] == tag_inv_addr)
      c_sh[tag_inv_addr[2:0]] <= 1'b0;
    if (rst_n && tag_inv_valid && lg_n < 64) begin
      lg[lg_n] <= tag_inv_addr;
      lg_n <= lg_n + 1;
    end
  end

  function automatic bit c_hit(input logic [AW-1:0] a);
    return c_sh[a[2:0]] && (c_tag[a[2:0]] == a);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nedge(); @(negedge clk); endtask

  task automatic preload(input logic [AW-1:0] a, input logic [7:0] d);
    nedge(); pl_en = 1'b1; pl_addr = a; pl_dat = d;
    nedge(); pl_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      nedge(); snp_valid = 0; ld_req = 0; fence_req = 0;
    end
  endtask

  task automatic t_reset();
    nedge(); #1;
    chk(snp_ready == 1'b1, "R1 ready", snp_ready, 1);
    chk(tag_inv_valid == 1'b0, "R1 tag_valid", tag_inv_valid, 0);
    chk(ld_stall == 1'b0, "R1 stall", ld_stall, 0);
  endtask

  task automatic t_order();
    int base;
    base = lg_n;
    nedge(); snp_valid = 1; snp_addr = 16'h0A01; #1;
    chk(snp_ready == 1'b1, "R2 ack first", snp_ready, 1);
    chk(tag_inv_valid == 1'b0, "R3 no same-cycle tag", tag_inv_valid, 0);
    nedge(); snp_addr = 16'h0B02; #1;
    chk(snp_ready == 1'b1, "R2 ack second", snp_ready, 1);
    chk(tag_inv_valid && tag_inv_addr == 16'h0A01, "R3 head addr", tag_inv_addr, 16'h0A01);
    nedge(); snp_addr = 16'h0C03;
    nedge(); snp_valid = 0;
    idle(3);
    chk(lg_n - base == 3, "R4 command count", lg_n - base, 3);
    chk(lg[base] == 16'h0A01, "R4 order 0", lg[base], 16'h0A01);
    chk(lg[base+1] == 16'h0B02, "R4 order 1", lg[base+1], 16'h0B02);
    chk(lg[base+2] == 16'h0C03, "R4 order 2", lg[base+2], 16'h0C03);
  endtask

  task automatic t_full();
    int base;
    base = lg_n;
    for (int i = 0; i < DEPTH; i++) begin
      nedge(); ld_req = 1; snp_valid = 1; snp_addr = 16'h1000 + 16'(i); #1;
      chk(snp_ready == 1'b1, "R2 ack under load", snp_ready, 1);
      chk(tag_inv_valid == 1'b0, "R5 core owns port", tag_inv_valid, 0);
    end
    nedge(); snp_addr = 16'h1FFF; #1;
    chk(snp_ready == 1'b0, "R6 full backpressure", snp_ready, 0);
    nedge(); ld_req = 0; #1;
    chk(snp_ready == 1'b0, "R6 still full in pop cycle", snp_ready, 0);
    nedge(); #1;
    chk(snp_ready == 1'b1, "R6 slot freed", snp_ready, 1);
    nedge(); snp_valid = 0;
    idle(6);
    chk(lg_n - base == DEPTH + 1, "R6 all applied", lg_n - base, DEPTH + 1);
    chk(lg[base+DEPTH] == 16'h1FFF, "R6 held entry last", lg[base+DEPTH], 16'h1FFF);
  endtask

  task automatic t_stale();
    preload(16'h0105, 8'hA5);
    preload(16'h0106, 8'h66);
    nedge(); ld_req = 1; snp_valid = 1; snp_addr = 16'h0105;
    nedge(); snp_addr = 16'h0206;
    nedge(); snp_valid = 0; #1;
    chk(ld_stall == 1'b0, "R9 no stall without barrier", ld_stall, 0);
    chk(c_hit(16'h0105) && c_dat[5] == 8'hA5, "R9 stale shared read", c_dat[5], 8'hA5);
    nedge(); ld_req = 0;
    idle(3);
    chk(!c_hit(16'h0105), "R3 matching line invalid", c_hit(16'h0105), 0);
    chk(c_hit(16'h0106), "R3 non-matching line kept", c_hit(16'h0106), 1);
  endtask

  task automatic t_fence();
    int stalled;
    preload(16'h0302, 8'h32);
    for (int i = 0; i < 3; i++) begin
      nedge(); ld_req = 1; snp_valid = 1; snp_addr = 16'h0300 + 16'(i + 1);
    end
    nedge(); snp_valid = 0; fence_req = 1; #1;
    chk(ld_stall == 1'b1, "R7 stall same cycle", ld_stall, 1);
    stalled = 1;
    for (int i = 0; i < 5; i++) begin
      nedge(); fence_req = 0; #1;
      if (ld_stall) stalled++;
    end
    chk(stalled == 3, "R7 stall length", stalled, 3);
    chk(!c_hit(16'h0302), "R7 line gone after barrier", c_hit(16'h0302), 0);
    nedge(); ld_req = 0;
  endtask

  task automatic t_fence_empty();
    nedge(); fence_req = 1; ld_req = 1; #1;
    chk(ld_stall == 1'b0, "R8 empty barrier", ld_stall, 0);
    nedge(); fence_req = 0; #1;
    chk(ld_stall == 1'b0, "R8 no later stall", ld_stall, 0);
    nedge(); ld_req = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin c_tag[i] = '0; c_sh[i] = 1'b0; c_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_full();
    t_stale();
    t_fence();
    t_fence_empty();
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule